// File: doc/BRIEF.md
# Rise-Time Boost Pulse Controller

This block decides, for each lane of a two-wire open-drain repeater, when a short pull-up boost should be applied to both sides of that lane. Each lane sees two digital levels, one per side, that are already compared against the release threshold, plus a flag from the repeater that says a driving direction currently owns the lane. When a lane that was pulled low is released and both sides have crossed the threshold, the controller issues a boost strobe for a programmable number of clock cycles. During the strobe it also tells the repeater to let go of its side-to-side coupling, so that each side can rise on its own.

Boosting is gated twice. A global accelerator-enable input can switch it off while the repeater keeps working normally, and the repeater's connect flag must be high. Lanes are independent copies. The default build has two lanes, one for data and one for clock. No stream data crosses this block, so all pins are plain control and status signals.

Top module: `rta_boost_ctrl`

## Requirements
- R1: A boost strobe can begin only after the lane has been armed. A strobe never starts on a falling edge. The first strobe cycle is the cycle after the clock edge that sampled both sides high while the lane was armed.
- R2: A lane fires only when both `side_a_hi` and `side_b_hi` are 1. While only one side is high, an armed lane stays armed and does not fire.
- R3: A strobe lasts exactly `pulse_cycles` clock cycles. If `pulse_cycles` is 0, no strobe is issued and the lane returns to idle.
- R4: In every cycle, `boost_a[i]` equals `boost_b[i]`.
- R5: While `acc_en` is 0, no strobe is issued. A lane that is armed or pulsing returns to idle, and the repeater keeps working.
- R6: While `link_up` is 0, no strobe is issued, and lanes return to idle exactly as in R5.
- R7: `decouple[i]` is 1 exactly in the cycles in which lane i strobes.
- R8: A new trigger during a strobe has no effect on it. After a strobe a lane re-arms only when both sides are sampled low while `lane_owned[i]` is 1.
- R9: If either side of a strobing lane goes low, the strobe drops in that same cycle. The lane then goes to idle and must be re-armed per R8.
- R10: Lanes are independent. Activity on one lane never produces a strobe on another lane. Bit i of every per-lane port belongs to lane i, and lane 0 is bit 0.
- R11: After reset every output is 0 and every lane is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Accelerator enable; 0 blocks all strobes |
| link_up | input | 1 | Repeater connected state; 0 blocks all strobes |
| pulse_cycles | input | CW | Strobe length in clock cycles |
| side_a_hi | input | NLANES | Side A level above release threshold, one bit per lane |
| side_b_hi | input | NLANES | Side B level above release threshold, one bit per lane |
| lane_owned | input | NLANES | Repeater has an active driving direction on the lane |
| boost_a | output | NLANES | Boost strobe for side A |
| boost_b | output | NLANES | Boost strobe for side B |
| decouple | output | NLANES | Request to release side-to-side coupling |

## Verification
Two functions of this block can fall in the same cycle: natural expiry of the strobe and the cut that happens when a side is pulled low. The bench provokes this by pulling one side low in exactly the last cycle of a strobe. It expects that cycle to show no boost, one high cycle fewer than a full strobe, and no new strobe when the side is released again without re-arming. A second collision comes from dropping the accelerator enable in the middle of a strobe. The strobe must fall at once, and restoring the enable must not resume it.

// File: rtl/rta_pkg.sv
`timescale 1ns/1ps
package rta_pkg;
  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_ARMED = 2'd1,
    LN_PULSE = 2'd2
  } lane_st_e;

  typedef struct packed {
    logic boost_a;
    logic boost_b;
    logic decouple;
  } lane_out_t;
endpackage

// File: rtl/rta_pulse_timer.sv
`timescale 1ns/1ps
module rta_pulse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          last
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (load)               cnt <= len;
    else if (run && cnt != '0)   cnt <= cnt - ONE;
  end

  assign last = (cnt == ONE);

  AST_TIMER_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !clr && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R3
endmodule

// File: rtl/rta_lane.sv
`timescale 1ns/1ps
module rta_lane
  import rta_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic          a_hi,
  input  logic          b_hi,
  input  logic          owned,
  input  logic [CW-1:0] len,
  output lane_out_t     o
);
  lane_st_e      st, st_nxt;
  logic          both_low, both_high;
  logic          t_clr, t_load, t_run, t_last;
  logic [CW-1:0] t_cnt;

  assign both_low  = !a_hi && !b_hi;
  assign both_high = a_hi && b_hi;

  always_comb begin
    st_nxt = st;
    if (!gate) begin
      st_nxt = LN_IDLE;
    end else begin
      unique case (st)
        LN_IDLE:  if (both_low && owned) st_nxt = LN_ARMED;
        LN_ARMED: if (both_high)         st_nxt = (len != '0) ? LN_PULSE : LN_IDLE;
        LN_PULSE: if (!both_high || t_last) st_nxt = LN_IDLE;
        default:  st_nxt = LN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= LN_IDLE;
    else        st <= st_nxt;
  end

  assign t_load = gate && (st == LN_ARMED) && both_high;
  assign t_run  = (st == LN_PULSE);
  assign t_clr  = (st_nxt == LN_IDLE) && !t_load;

  rta_pulse_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (t_clr),
    .load (t_load),
    .len  (len),
    .run  (t_run),
    .cnt  (t_cnt),
    .last (t_last)
  );

  logic fire;
  assign fire       = gate && (st == LN_PULSE) && both_high;
  assign o.boost_a  = fire;
  assign o.boost_b  = fire;
  assign o.decouple = fire;

  AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (st == LN_IDLE)); // R5
  AST_CUT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LN_PULSE && !both_high) |=> (st == LN_IDLE)); // R9
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LN_PULSE && $past(st == LN_PULSE)) |-> (t_cnt < $past(t_cnt))); // R8
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LN_PULSE) |-> (t_cnt != '0)); // R3
endmodule

// File: rtl/rta_boost_ctrl.sv
`timescale 1ns/1ps
module rta_boost_ctrl
  import rta_pkg::*;
#(
  parameter int NLANES = 2,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              link_up,
  input  logic [CW-1:0]     pulse_cycles,
  input  logic [NLANES-1:0] side_a_hi,
  input  logic [NLANES-1:0] side_b_hi,
  input  logic [NLANES-1:0] lane_owned,
  output logic [NLANES-1:0] boost_a,
  output logic [NLANES-1:0] boost_b,
  output logic [NLANES-1:0] decouple
);
  logic gate;
  assign gate = acc_en && link_up;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    lane_out_t lo;
    rta_lane #(.CW(CW)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .gate (gate),
      .a_hi (side_a_hi[i]),
      .b_hi (side_b_hi[i]),
      .owned(lane_owned[i]),
      .len  (pulse_cycles),
      .o    (lo)
    );
    assign boost_a[i]  = lo.boost_a;
    assign boost_b[i]  = lo.boost_b;
    assign decouple[i] = lo.decouple;

    AST_RISE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boost_a[i]) |-> ($past(side_a_hi[i]) && $past(side_b_hi[i]))); // R2
  end
endmodule

// File: tb/tb_rta_boost_ctrl.sv
`timescale 1ns/1ps
module tb_rta_boost_ctrl;
  localparam int NL = 2;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_en = 1'b0, link_up = 1'b0;
  logic [CW-1:0] pulse_cycles = '0;
  logic [NL-1:0] side_a_hi = '0, side_b_hi = '0, lane_owned = '0;
  logic [NL-1:0] boost_a, boost_b, decouple;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rta_boost_ctrl #(.NLANES(NL), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .link_up(link_up),
    .pulse_cycles(pulse_cycles), .side_a_hi(side_a_hi), .side_b_hi(side_b_hi),
    .lane_owned(lane_owned), .boost_a(boost_a), .boost_b(boost_b), .decouple(decouple)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // both sides low with ownership for two edges -> lane armed (when gated on)
  task automatic arm(input int l);
    tick();
    side_a_hi[l] = 1'b0; side_b_hi[l] = 1'b0; lane_owned[l] = 1'b1;
    tick(); tick();
    lane_owned[l] = 1'b0;
  endtask

  // observe n cycles; count boost cycles on lane l, check R4/R7/R10 each cycle
  task automatic observe(input int l, input int n, output int hi, output int first);
    hi = 0; first = -1;
    for (int k = 1; k <= n; k++) begin
      tick(); #2;
      if (boost_a[l]) begin hi++; if (first < 0) first = k; end
      chk("R4 sides equal", int'(boost_b[l]), int'(boost_a[l]));
      chk("R7 decouple", int'(decouple[l]), int'(boost_a[l]));
      chk("R10 other lane quiet", int'(boost_a[1-l]), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int hi, first;
    repeat (3) tick();
    #2;
    chk("R11 reset boost_a", int'(boost_a), 0);
    chk("R11 reset boost_b", int'(boost_b), 0);
    chk("R11 reset decouple", int'(decouple), 0);
    rst_n = 1'b1;
    tick();

    // sweep: gates x length x lane
    for (int g = 0; g < 4; g++) begin
      for (int p = 0; p < 16; p++) begin
        for (int l = 0; l < NL; l++) begin
          acc_en = g[0]; link_up = g[1];
          pulse_cycles = CW'(p);
          side_a_hi = '0; side_b_hi = '0; lane_owned = '0;
          arm(l);
          side_a_hi[l] = 1'b1; side_b_hi[l] = 1'b1;
          #2;
          chk("R1 no boost in release cycle", int'(boost_a[l]), 0);
          observe(l, p + 3, hi, first);
          if (g == 3) begin
            chk("R3 pulse length", hi, p);
            if (p > 0) chk("R1 first boost cycle", first, 1);
          end else if (g == 1) begin
            chk("R6 link down blocks", hi, 0);
          end else begin
            chk("R5 enable low blocks", hi, 0);
          end
        end
      end
    end

    acc_en = 1'b1; link_up = 1'b1;

    // R2: one side only keeps lane armed
    pulse_cycles = 4'd5;
    side_a_hi = '0; side_b_hi = '0;
    arm(0);
    side_a_hi[0] = 1'b1;
    observe(0, 6, hi, first);
    chk("R2 one side high no boost", hi, 0);
    side_b_hi[0] = 1'b1;
    observe(0, 8, hi, first);
    chk("R2 both high fires", hi, 5);

    // R9: cut mid-pulse, no resume
    pulse_cycles = 4'd8;
    arm(0);
    side_a_hi[0] = 1'b1; side_b_hi[0] = 1'b1;
    observe(0, 3, hi, first);
    chk("R9 pre-cut boost", hi, 3);
    side_a_hi[0] = 1'b0; #2;
    chk("R9 cut same cycle", int'(boost_a[0]), 0);
    tick(); side_a_hi[0] = 1'b1;
    observe(0, 10, hi, first);
    chk("R9 no resume after cut", hi, 0);

    // collision: cut in the last pulse cycle
    pulse_cycles = 4'd4;
    arm(0);
    side_a_hi[0] = 1'b1; side_b_hi[0] = 1'b1;
    observe(0, 3, hi, first);
    chk("R9 last-cycle pre", hi, 3);
    side_b_hi[0] = 1'b0; #2;
    chk("R9 last-cycle cut", int'(boost_a[0]), 0);
    tick(); side_b_hi[0] = 1'b1;
    observe(0, 6, hi, first);
    chk("R9 last-cycle no new pulse", hi, 0);

    // R8: trigger during pulse ignored; re-arm needs ownership
    pulse_cycles = 4'd6;
    arm(1);
    side_a_hi[1] = 1'b1; side_b_hi[1] = 1'b1;
    tick(); tick(); lane_owned[1] = 1'b1;
    observe(1, 8, hi, first);
    lane_owned[1] = 1'b0;
    chk("R8 pulse not extended", hi, 4);
    observe(1, 6, hi, first);
    chk("R8 no retrigger after", hi, 0);
    side_a_hi[1] = 1'b0; side_b_hi[1] = 1'b0;
    tick(); tick(); side_a_hi[1] = 1'b1; side_b_hi[1] = 1'b1;
    observe(1, 8, hi, first);
    chk("R8 unowned low does not re-arm", hi, 0);
    arm(1);
    side_a_hi[1] = 1'b1; side_b_hi[1] = 1'b1;
    observe(1, 9, hi, first);
    chk("R8 owned re-arm fires", hi, 6);

    // R5: enable drop mid-pulse
    pulse_cycles = 4'd10;
    arm(0);
    side_a_hi[0] = 1'b1; side_b_hi[0] = 1'b1;
    observe(0, 2, hi, first);
    acc_en = 1'b0; #2;
    chk("R5 drop mid-pulse", int'(boost_a[0]), 0);
    tick(); acc_en = 1'b1;
    observe(0, 12, hi, first);
    chk("R5 no resume after enable", hi, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule